// File: doc/BRIEF.md
# UART Bit-Rate and Oversampling Tick Generator

This block derives two single-cycle clock enables for a serial transmitter and receiver from one reference clock. A sample tick marks each oversampling instant and a bit tick marks the end of each bit period. The reference clock can pass through an optional divide-by-8 prescaler, then a programmable clock divider produces the sample tick, and a second programmable divider counts a programmable number of sample ticks to produce the bit tick. The resulting bit rate is the selected clock divided by `clk_div * (bit_div + 1)`.

The three settings are captured every cycle into holding registers. Any difference between the inputs and the held values restarts both counters from zero, so no bit period is ever built from a mix of old and new settings. The enable input freezes the generator at its starting point and silences both outputs. After reset the held settings are a clock divider of 0x3E, a bit divider of 6 and the prescaler off, so a system that drives exactly those values after reset starts counting without a restart cycle.

Top module: `uart_rate_gen`

## Requirements
- R1: With `pre8_sel` = 0 and `clk_div` = C >= 2, the first sample tick comes in the C-th cycle after counting starts (cycle C-1 counting the first as 0) and further ones every C cycles.
- R2: With `pre8_sel` = 1 the reference clock is divided by 8 before the clock divider, so sample ticks come in cycle 8*C-1 and every 8*C cycles after.
- R3: `bit_tick` is high only in the same cycle as `samp_tick`, and marks every (B+1)-th sample tick, where B is the effective bit divider.
- R4: The effective bit divider is `bit_div` limited to the range 4 to 254: values below 4 act as 4 and 255 acts as 254, so the bit rate never exceeds one fifth of the reference clock.
- R5: `clk_div` = 1 makes every prescaled clock cycle a sample tick; `clk_div` = 0 produces no sample tick and no bit tick.
- R6: A cycle in which `clk_div`, `bit_div` or `pre8_sel` differs from the value of the previous cycle emits no tick, and counting restarts from zero in the following cycle.
- R7: While `gen_en` is 0 both outputs stay low and the counters are held at zero; counting starts from zero in the first cycle with `gen_en` = 1.
- R8: Each tick is a single-cycle pulse; with the prescaler on, two sample ticks never occur in consecutive cycles.
- R9: During reset both outputs are low, and the held settings reset to a clock divider of 0x3E, a bit divider of 6 and the prescaler off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pre8_sel | input | 1 | 1 selects the divide-by-8 prescaler |
| clk_div | input | 16 | Clock divider for the sample tick |
| bit_div | input | 8 | Bit divider; one bit lasts bit_div+1 sample ticks |
| gen_en | input | 1 | Generator enable |
| samp_tick | output | 1 | Oversampling clock enable, one cycle wide |
| bit_tick | output | 1 | Bit-period clock enable, one cycle wide |

## Verification
The bench builds the block with its default parameters: 16-bit clock divider, 8-bit bit divider, a prescale ratio of 8 and bit-divider limits of 4 and 254. These make both clamp limits and the prescaler reachable within a few hundred cycles, since a clock divider of 1 with a bit divider of 255 gives a 255-cycle bit, while the reset values of the held settings are observed through the timing of the first ticks after reset. Restart on a settings change and on re-enable is checked by predicting tick cycles on both sides of the disturbance.

// File: rtl/uart_rate_pkg.sv
package uart_rate_pkg;

  localparam int RATE_CD_W      = 16;
  localparam int RATE_BDIV_W    = 8;
  localparam int RATE_PRE_RATIO = 8;
  localparam int RATE_BDIV_LO   = 4;
  localparam int RATE_BDIV_HI   = 254;
  localparam int RATE_CD_RST    = 'h3E;
  localparam int RATE_BDIV_RST  = 6;

  // Settings held between cycles, compared against the inputs.
  typedef struct packed {
    logic                   pre8;
    logic [RATE_CD_W-1:0]   cd;
    logic [RATE_BDIV_W-1:0] bdiv;
  } rate_cfg_t;

endpackage

// File: rtl/rate_prescaler.sv
module rate_prescaler #(
  parameter int RATIO = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic sel,
  output logic pre_tick
);

  generate
    if (RATIO > 1) begin : g_div
      localparam int W = $clog2(RATIO);
      localparam logic [W-1:0] LAST = W'(RATIO - 1);

      logic [W-1:0] cnt_q;
      logic [W-1:0] cnt_d;
      logic         wrap;

      assign wrap = (cnt_q == LAST);

      always_comb begin
        if (hold || !sel) begin
          cnt_d = '0;
        end else if (wrap) begin
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + W'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
        end
      end

      assign pre_tick = !hold && (!sel || wrap);
    end else begin : g_pass
      assign pre_tick = !hold;
    end
  endgenerate

endmodule

// File: rtl/rate_tick_div.sv
module rate_tick_div #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         ce,
  input  logic [W-1:0] div,
  output logic         tick
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         div_zero;
  logic         at_end;

  assign div_zero = (div == '0);
  assign at_end   = (cnt_q == div - W'(1));
  assign tick     = ce && !hold && !div_zero && at_end;

  always_comb begin
    if (hold || div_zero) begin
      cnt_d = '0;
    end else if (ce) begin
      cnt_d = at_end ? '0 : cnt_q + W'(1);
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/uart_rate_gen.sv
module uart_rate_gen
  import uart_rate_pkg::*;
#(
  parameter int CD_W      = RATE_CD_W,
  parameter int BDIV_W    = RATE_BDIV_W,
  parameter int PRE_RATIO = RATE_PRE_RATIO,
  parameter int BDIV_LO   = RATE_BDIV_LO,
  parameter int BDIV_HI   = RATE_BDIV_HI,
  parameter int CD_RST    = RATE_CD_RST,
  parameter int BDIV_RST  = RATE_BDIV_RST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre8_sel,
  input  logic [CD_W-1:0]   clk_div,
  input  logic [BDIV_W-1:0] bit_div,
  input  logic              gen_en,
  output logic              samp_tick,
  output logic              bit_tick
);

  localparam int BIT_W = BDIV_W + 1;
  localparam logic [BDIV_W-1:0] LO_V = BDIV_W'(BDIV_LO);
  localparam logic [BDIV_W-1:0] HI_V = BDIV_W'(BDIV_HI);

  // Held copy of the settings.
  logic              pre8_q, pre8_d;
  logic [CD_W-1:0]   cd_q, cd_d;
  logic [BDIV_W-1:0] bdiv_q, bdiv_d;

  logic              reload;
  logic              hold;
  logic [BDIV_W-1:0] bdiv_eff;
  logic [BIT_W-1:0]  bit_len;
  logic              pre_tick;

  always_comb begin
    pre8_d = pre8_sel;
    cd_d   = clk_div;
    bdiv_d = bit_div;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre8_q <= 1'b0;
      cd_q   <= CD_W'(CD_RST);
      bdiv_q <= BDIV_W'(BDIV_RST);
    end else begin
      pre8_q <= pre8_d;
      cd_q   <= cd_d;
      bdiv_q <= bdiv_d;
    end
  end

  assign reload = (pre8_sel != pre8_q) || (clk_div != cd_q) || (bit_div != bdiv_q);
  assign hold   = reload || !gen_en;

  always_comb begin
    if (bdiv_q < LO_V) begin
      bdiv_eff = LO_V;
    end else if (bdiv_q > HI_V) begin
      bdiv_eff = HI_V;
    end else begin
      bdiv_eff = bdiv_q;
    end
  end

  assign bit_len = {1'b0, bdiv_eff} + BIT_W'(1);

  rate_prescaler #(
    .RATIO (PRE_RATIO)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (hold),
    .sel      (pre8_q),
    .pre_tick (pre_tick)
  );

  rate_tick_div #(
    .W (CD_W)
  ) u_samp (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (hold),
    .ce    (pre_tick),
    .div   (cd_q),
    .tick  (samp_tick)
  );

  rate_tick_div #(
    .W (BIT_W)
  ) u_bit (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (hold),
    .ce    (samp_tick),
    .div   (bit_len),
    .tick  (bit_tick)
  );

endmodule

// File: rtl/uart_rate_gen_chk.sv
module uart_rate_gen_chk #(
  parameter int CD_W   = 16,
  parameter int BDIV_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pre8_sel,
  input logic [CD_W-1:0]   clk_div,
  input logic [BDIV_W-1:0] bit_div,
  input logic              gen_en,
  input logic              samp_tick,
  input logic              bit_tick
);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |-> (!samp_tick && !bit_tick));

  a_r3_bit_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> samp_tick);

  a_r5_zero_div_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_div == '0) |-> (!samp_tick && !bit_tick));

  a_r8_pre8_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (pre8_sel && samp_tick) |=> !samp_tick);

  a_r6_change_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(clk_div) || !$stable(bit_div) || !$stable(pre8_sel)) |-> !samp_tick);

endmodule

bind uart_rate_gen uart_rate_gen_chk #(
  .CD_W   (CD_W),
  .BDIV_W (BDIV_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pre8_sel  (pre8_sel),
  .clk_div   (clk_div),
  .bit_div   (bit_div),
  .gen_en    (gen_en),
  .samp_tick (samp_tick),
  .bit_tick  (bit_tick)
);

// File: tb/uart_rate_gen_test.sv
module uart_rate_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  typedef struct {
    int    t;
    string tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        pre8_sel;
  logic [15:0] clk_div;
  logic [7:0]  bit_div;
  logic        gen_en;
  logic        samp_tick;
  logic        bit_tick;

  int   cyc;
  int   n_checks;
  int   n_fail;
  exp_t sq[$];
  exp_t bq[$];

  uart_rate_gen uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pre8_sel  (pre8_sel),
    .clk_div   (clk_div),
    .bit_div   (bit_div),
    .gen_en    (gen_en),
    .samp_tick (samp_tick),
    .bit_tick  (bit_tick)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // Monitor: compare every tick against the head of its queue.
  always @(negedge clk) begin
    if (rst_n) begin
      if (samp_tick) begin
        n_checks++;
        if (sq.size() == 0) begin
          n_fail++;
          $display("FAIL unexpected sample tick at cycle %0d, expected none", cyc);
        end else begin
          exp_t e;
          e = sq.pop_front();
          if (e.t != cyc) begin
            n_fail++;
            $display("FAIL %s sample tick at cycle %0d, expected %0d", e.tag, cyc, e.t);
          end
        end
      end
      if (bit_tick) begin
        n_checks++;
        if (bq.size() == 0) begin
          n_fail++;
          $display("FAIL unexpected bit tick at cycle %0d, expected none", cyc);
        end else begin
          exp_t e;
          e = bq.pop_front();
          if (e.t != cyc) begin
            n_fail++;
            $display("FAIL %s bit tick at cycle %0d, expected %0d", e.tag, cyc, e.t);
          end
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic run_until(input int last);
    while (cyc < last) step();
  endtask

  function automatic int clamp_bdiv(input int b);
    if (b < 4) return 4;       // R4 lower limit
    if (b > 254) return 254;   // R4 upper limit
    return b;
  endfunction

  // Driver side of the scoreboard: push predicted tick cycles.
  task automatic push_exp(input int start, input int c, input int b, input bit sel,
                          input int last, input string tag);
    int p;
    int be;
    exp_t e;
    p  = sel ? 8 : 1;
    be = clamp_bdiv(b);
    e.tag = tag;
    if (c == 0) return;
    for (int j = 1; start + p * c * j - 1 <= last; j++) begin
      e.t = start + p * c * j - 1;
      sq.push_back(e);
    end
    for (int m = 1; start + p * c * (be + 1) * m - 1 <= last; m++) begin
      e.t = start + p * c * (be + 1) * m - 1;
      bq.push_back(e);
    end
  endtask

  task automatic check_empty(input string tag);
    n_checks++;
    if (sq.size() != 0 || bq.size() != 0) begin
      n_fail++;
      $display("FAIL %s missing ticks: %0d sample and %0d bit pending, expected 0 and 0",
               tag, sq.size(), bq.size());
    end
    sq.delete();
    bq.delete();
  endtask

  task automatic start_cfg(input int c, input int b, input bit sel, output int n);
    gen_en   = 1'b0;
    clk_div  = 16'(c);
    bit_div  = 8'(b);
    pre8_sel = sel;
    step();
    step();
    step();
    n = cyc;
    gen_en = 1'b1;
  endtask

  task automatic run_cfg(input int c, input int b, input bit sel, input int win,
                         input string tag);
    int n;
    start_cfg(c, b, sel, n);
    push_exp(n, c, b, sel, n + win - 1, tag);
    run_until(n + win);
    gen_en = 1'b0;
    check_empty(tag);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
    report();
  end

  initial begin
    int n;
    int m;
    int q;
    n_checks = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    gen_en   = 1'b1;
    pre8_sel = 1'b0;
    clk_div  = 16'h003E;
    bit_div  = 8'd6;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: outputs low during reset
    n_checks++;
    if (samp_tick !== 1'b0 || bit_tick !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 ticks during reset %b%b, expected 00", samp_tick, bit_tick);
    end

    // R9: reset settings match these inputs, so counting starts at once
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    push_exp(0, 62, 6, 1'b0, 499, "R9 R1");
    run_until(500);
    gen_en = 1'b0;
    check_empty("R9");

    run_cfg(3, 4, 1'b0, 60, "R1 R3");
    run_cfg(2, 5, 1'b1, 400, "R2 R8");
    run_cfg(1, 4, 1'b0, 30, "R5 R4");
    run_cfg(0, 6, 1'b0, 50, "R5");
    run_cfg(1, 2, 1'b0, 40, "R4");
    run_cfg(1, 255, 1'b0, 600, "R4");

    // R6: divider change mid-run restarts counting
    start_cfg(4, 4, 1'b0, n);
    m = n + 30;
    push_exp(n, 4, 4, 1'b0, m - 1, "R6");
    run_until(m);
    clk_div = 16'd3;
    push_exp(m + 1, 3, 4, 1'b0, m + 40, "R6");
    run_until(m + 41);
    gen_en = 1'b0;
    check_empty("R6");

    // R6: bit divider change alone also restarts
    start_cfg(2, 4, 1'b0, n);
    m = n + 17;
    push_exp(n, 2, 4, 1'b0, m - 1, "R6");
    run_until(m);
    bit_div = 8'd5;
    push_exp(m + 1, 2, 5, 1'b0, m + 40, "R6");
    run_until(m + 41);
    gen_en = 1'b0;
    check_empty("R6");

    // R7: enable drop holds counters at zero
    start_cfg(5, 4, 1'b0, n);
    m = n + 23;
    push_exp(n, 5, 4, 1'b0, m - 1, "R7");
    run_until(m);
    gen_en = 1'b0;
    run_until(m + 10);
    q = cyc;
    gen_en = 1'b1;
    push_exp(q, 5, 4, 1'b0, q + 39, "R7");
    run_until(q + 40);
    gen_en = 1'b0;
    check_empty("R7");

    // R7: nothing while disabled
    run_until(cyc + 20);
    check_empty("R7");

    report();
  end

endmodule